// File: doc/BRIEF.md
# Clear-on-Read Interrupt Aggregator

This block gathers event indications from two groups of sources into latched flag registers and drives one active-low interrupt line towards a host processor. The global group takes seven single-cycle event pulses. The charger group watches several multi-bit status fields and raises a flag whenever a field changes value. It also takes one pulse that reports a forced change of the system configuration. Each group has a mask register of its own. Masking decides which newly set flags may pull the line low.

A small synchronous register port gives the host read access to the two flag registers and read/write access to the two mask registers. Reading a flag register returns every event recorded since the previous read of that register, and clears it in the same action. The interrupt line falls when a flag that is not masked goes from 0 to 1. It stays low until every flag in both groups has been cleared by reads. A separate status output mirrors the internal interrupt drive level, so software can see that level directly.

Top module: `irq_collector`

## Requirements
- R1: After a synchronous reset both flag registers read 0x00, both mask registers read 0xFF, `irq_n` is 1 and `irq_stat` is 0.
- R2: A pulse on `gl_pulse[i]` (i = 0..6) sets bit i of the global flag register at address 0x00. Bit 7 of that register always reads 0. Read data appears on `rd_data` in the cycle after the read request.
- R3: Reading a flag register clears it, so a second read with no event in between returns 0x00. Several events of the same source before a read leave one bit set.
- R4: If an event arrives in the same cycle as a read of its register, the read returns the value from before the clear, and the flag is set afterwards.
- R5: Mask registers are written and read back at address 0x06 (global) and 0x07 (charger). A mask bit of 1 masks the flag bit at the same position.
- R6: When an event sets a flag bit that was 0 and whose mask bit is 0, `irq_n` is 0 from the clock edge that sets the flag.
- R7: A flag that sets while masked does not lower `irq_n`. Clearing its mask bit later, while the flag is still set, does not lower `irq_n` either.
- R8: Once low, `irq_n` returns to 1 only at the clock edge where every flag of both groups, masked or not, is 0.
- R9: The charger flag register at address 0x01 sets bit 0 on a change of `therm_stat`, bit 1 on a change of `chg_state`, bit 2 on a change of `in_stat`, bit 3+k on a change of `loop_stat[k]` (k = 0..2), and bit 6 on a pulse of `cfg_forced`. Bit 7 always reads 0.
- R10: Status changes made while reset is asserted raise no flag, either during reset or after it is released.
- R11: `irq_stat` is always the inverse of `irq_n`.
- R12: A read of an unmapped address returns 0x00. A write to a flag register address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| gl_pulse | input | 7 | Global event pulses, bit i sets global flag bit i |
| in_stat | input | 2 | Charger input status field, watched for change |
| chg_state | input | 4 | Charger state field, watched for change |
| therm_stat | input | 3 | Thermistor status field, watched for change |
| loop_stat | input | 3 | Control-loop status bits, each watched for change |
| cfg_forced | input | 1 | Pulse reporting a forced configuration change |
| rd_en | input | 1 | Register read request |
| wr_en | input | 1 | Register write request |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data, valid the cycle after `rd_en` |
| irq_n | output | 1 | Active-low interrupt line |
| irq_stat | output | 1 | Internal interrupt drive level, 1 while the line is pulled low |

## Verification
The bound checker checks, on every cycle, the relationships that need no history beyond one clock. These are the reset values of masks, flags and the line, the complementary pair `irq_n`/`irq_stat`, the line falling after an unmasked new global flag, the line rising only with both flag registers empty, mask write-back, and a read with no event leaving the global flags empty. Only the bench scenarios show the behaviours that depend on an order of register accesses. These are a read colliding with an event, a masked flag holding the line low after the unmasked ones are read, a mask lifted after its flag set, the mapping of each charger field to its bit, and status changes hidden by reset.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] GLB_FLAG_ADDR = 8'h00;
  localparam logic [ADDR_W-1:0] CHG_FLAG_ADDR = 8'h01;
  localparam logic [ADDR_W-1:0] GLB_MASK_ADDR = 8'h06;
  localparam logic [ADDR_W-1:0] CHG_MASK_ADDR = 8'h07;

  // bits that can ever be set in each flag register (bit 7 reserved)
  localparam logic [DATA_W-1:0] GLB_LIVE = 8'h7F;
  localparam logic [DATA_W-1:0] CHG_LIVE = 8'h7F;

  // charger flag positions
  localparam int CHG_THERM_BIT = 0;
  localparam int CHG_STATE_BIT = 1;
  localparam int CHG_INPUT_BIT = 2;
  localparam int CHG_LOOP_BIT  = 3;
  localparam int CHG_FORCE_BIT = 6;
endpackage

// File: rtl/irq_chg_detect.sv
module irq_chg_detect #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] field,
  output logic         changed
);
  logic [W-1:0] prev_q;

  // during reset the field is tracked so no stale difference survives release
  always_ff @(posedge clk) begin
    prev_q <= field;
  end

  assign changed = (field != prev_q) && !rst;
endmodule

// File: rtl/irq_flag_group.sv
module irq_flag_group #(
  parameter int                W         = 8,
  parameter int                AW        = 8,
  parameter logic [AW-1:0]     FLAG_ADDR = '0,
  parameter logic [AW-1:0]     MASK_ADDR = '0,
  parameter logic [W-1:0]      LIVE      = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  evt,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  flags_o,
  output logic [W-1:0]  mask_o,
  output logic          raise_o,
  output logic          clear_next_o
);
  logic [W-1:0] flags_q, mask_q, flags_d, evt_live;
  logic         rd_hit, wr_hit;

  assign rd_hit   = rd_en && (addr == FLAG_ADDR);
  assign wr_hit   = wr_en && (addr == MASK_ADDR);
  assign evt_live = evt & LIVE;

  // a read drops old bits, an event in the same cycle still lands
  assign flags_d      = (rd_hit ? '0 : flags_q) | evt_live;
  assign raise_o      = |(evt_live & ~flags_q & ~mask_q);
  assign clear_next_o = (flags_d == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      mask_q  <= '1;
    end else begin
      flags_q <= flags_d;
      if (wr_hit) mask_q <= wr_data;
    end
  end

  assign flags_o = flags_q;
  assign mask_o  = mask_q;
endmodule

// File: rtl/irq_drive.sv
module irq_drive (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic all_clear_next,
  output logic drive_o,
  output logic line_n_o
);
  logic drive_q, line_n_q, drive_d;

  always_comb begin
    drive_d = drive_q;
    if (raise)               drive_d = 1'b1;
    else if (all_clear_next) drive_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q  <= 1'b0;
      line_n_q <= 1'b1;
    end else begin
      drive_q  <= drive_d;
      line_n_q <= !drive_d;
    end
  end

  assign drive_o  = drive_q;
  assign line_n_o = line_n_q;
endmodule

// File: rtl/irq_collector.sv
module irq_collector
  import irq_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int DW       = DATA_W,
  parameter int GL_N     = 7,
  parameter int IN_W     = 2,
  parameter int STATE_W  = 4,
  parameter int THERM_W  = 3,
  parameter int LOOP_N   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [GL_N-1:0]    gl_pulse,
  input  logic [IN_W-1:0]    in_stat,
  input  logic [STATE_W-1:0] chg_state,
  input  logic [THERM_W-1:0] therm_stat,
  input  logic [LOOP_N-1:0]  loop_stat,
  input  logic               cfg_forced,
  input  logic               rd_en,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [DW-1:0]      wr_data,
  output logic [DW-1:0]      rd_data,
  output logic               irq_n,
  output logic               irq_stat
);
  localparam int GL_PAD = DW - GL_N;

  logic [DW-1:0]     glb_evt, chg_evt;
  logic [DW-1:0]     glb_flags, glb_mask, chg_flags, chg_mask;
  logic              glb_raise, chg_raise, glb_clr, chg_clr;
  logic              in_chg, state_chg, therm_chg;
  logic [LOOP_N-1:0] loop_chg;
  logic [DW-1:0]     rd_q;

  assign glb_evt = {{GL_PAD{1'b0}}, gl_pulse};

  irq_chg_detect #(.W(IN_W)) u_in (
    .clk(clk), .rst(rst), .field(in_stat), .changed(in_chg));
  irq_chg_detect #(.W(STATE_W)) u_state (
    .clk(clk), .rst(rst), .field(chg_state), .changed(state_chg));
  irq_chg_detect #(.W(THERM_W)) u_therm (
    .clk(clk), .rst(rst), .field(therm_stat), .changed(therm_chg));

  for (genvar k = 0; k < LOOP_N; k++) begin : g_loop
    irq_chg_detect #(.W(1)) u_loop (
      .clk(clk), .rst(rst), .field(loop_stat[k]), .changed(loop_chg[k]));
  end

  always_comb begin
    chg_evt                              = '0;
    chg_evt[CHG_THERM_BIT]               = therm_chg;
    chg_evt[CHG_STATE_BIT]               = state_chg;
    chg_evt[CHG_INPUT_BIT]               = in_chg;
    chg_evt[CHG_LOOP_BIT +: LOOP_N]      = loop_chg;
    chg_evt[CHG_FORCE_BIT]               = cfg_forced && !rst;
  end

  irq_flag_group #(.W(DW), .AW(AW), .FLAG_ADDR(GLB_FLAG_ADDR),
                   .MASK_ADDR(GLB_MASK_ADDR), .LIVE(GLB_LIVE)) u_glb (
    .clk(clk), .rst(rst), .evt(glb_evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .flags_o(glb_flags), .mask_o(glb_mask),
    .raise_o(glb_raise), .clear_next_o(glb_clr));

  irq_flag_group #(.W(DW), .AW(AW), .FLAG_ADDR(CHG_FLAG_ADDR),
                   .MASK_ADDR(CHG_MASK_ADDR), .LIVE(CHG_LIVE)) u_chg (
    .clk(clk), .rst(rst), .evt(chg_evt), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wr_data(wr_data), .flags_o(chg_flags), .mask_o(chg_mask),
    .raise_o(chg_raise), .clear_next_o(chg_clr));

  irq_drive u_drv (
    .clk(clk), .rst(rst), .raise(glb_raise || chg_raise),
    .all_clear_next(glb_clr && chg_clr), .drive_o(irq_stat), .line_n_o(irq_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else if (rd_en) begin
      case (addr)
        GLB_FLAG_ADDR: rd_q <= glb_flags;
        CHG_FLAG_ADDR: rd_q <= chg_flags;
        GLB_MASK_ADDR: rd_q <= glb_mask;
        CHG_MASK_ADDR: rd_q <= chg_mask;
        default:       rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/irq_collector_chk.sv
module irq_collector_chk
  import irq_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int GL_N = 7
) (
  input logic            clk,
  input logic            rst,
  input logic [GL_N-1:0] gl_pulse,
  input logic            rd_en,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wr_data,
  input logic            irq_n,
  input logic            irq_stat,
  input logic [DW-1:0]   gflags,
  input logic [DW-1:0]   gmask,
  input logic [DW-1:0]   cflags,
  input logic [DW-1:0]   cmask
);
  localparam int GL_PAD = DW - GL_N;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (irq_n && !irq_stat && gmask == '1 && cmask == '1 &&
             gflags == '0 && cflags == '0));

  // R11
  stat_mirror_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n != irq_stat);

  // R6
  unmasked_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (|({{GL_PAD{1'b0}}, gl_pulse} & ~gflags & ~gmask)) |=> !irq_n);

  // R8
  release_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> (gflags == '0 && cflags == '0));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == GLB_FLAG_ADDR && gl_pulse == '0) |=> gflags == '0);

  // R5
  mask_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == GLB_MASK_ADDR) |=> gmask == $past(wr_data));
endmodule

bind irq_collector irq_collector_chk #(.AW(AW), .DW(DW), .GL_N(GL_N)) u_chk (
  .clk(clk), .rst(rst), .gl_pulse(gl_pulse), .rd_en(rd_en), .wr_en(wr_en),
  .addr(addr), .wr_data(wr_data), .irq_n(irq_n), .irq_stat(irq_stat),
  .gflags(glb_flags), .gmask(glb_mask), .cflags(chg_flags), .cmask(chg_mask));

// File: tb/irq_collector_bench.sv
module irq_collector_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] gl_pulse = '0;
  logic [1:0] in_stat = '0;
  logic [3:0] chg_state = '0;
  logic [2:0] therm_stat = '0;
  logic [2:0] loop_stat = '0;
  logic       cfg_forced = 1'b0;
  logic       rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_n, irq_stat;

  int total = 0, bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_d = 1'b0;

  always #5 clk = ~clk;

  irq_collector u_irq_collector (
    .clk(clk), .rst(rst), .gl_pulse(gl_pulse), .in_stat(in_stat),
    .chg_state(chg_state), .therm_stat(therm_stat), .loop_stat(loop_stat),
    .cfg_forced(cfg_forced), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_n(irq_n), .irq_stat(irq_stat));

  always @(posedge clk) rd_d <= rd_en;

  // monitor: pops one expectation per returned read
  always @(negedge clk) begin
    if (rd_d) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read data act=%h exp=none", rd_data);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          bad++;
          $display("FAIL %s act=%h exp=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_line(string tag, logic exp_n);
    chk({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, exp_n});
    chk({tag, " irq_stat"}, {7'd0, irq_stat}, {7'd0, !exp_n});
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [6:0] b);
    @(negedge clk);
    gl_pulse = b;
    @(negedge clk);
    gl_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_line("R1 reset", 1'b1);
    rd(8'h06, 8'hFF, "R1 glb mask reset");
    rd(8'h07, 8'hFF, "R1 chg mask reset");
    rd(8'h00, 8'h00, "R1 glb flags reset");
    rd(8'h01, 8'h00, "R1 chg flags reset");

    // masked event, set and clear-on-read
    pulse(7'h10);
    chk_line("R7 masked event", 1'b1);
    rd(8'h00, 8'h10, "R2 glb bit4");
    rd(8'h00, 8'h00, "R3 cleared");
    pulse(7'h20); pulse(7'h20);
    rd(8'h00, 8'h20, "R3 repeated event one bit");

    // masks
    wr(8'h06, 8'hFE);
    wr(8'h07, 8'hFB);
    rd(8'h06, 8'hFE, "R5 glb mask");
    rd(8'h07, 8'hFB, "R5 chg mask");

    // unmasked event pulls line, read releases
    pulse(7'h01);
    chk_line("R6 unmasked fall", 1'b0);
    pulse(7'h08);
    rd(8'h00, 8'h09, "R2 glb bits 0 and 3");
    chk_line("R8 release after read", 1'b1);

    // masked pending flag in other group holds line low
    pulse(7'h01);
    @(negedge clk); therm_stat = 3'd5;
    @(negedge clk);
    rd(8'h00, 8'h01, "R8 glb read");
    chk_line("R8 held by masked chg flag", 1'b0);
    rd(8'h01, 8'h01, "R9 therm bit0");
    chk_line("R8 release when all clear", 1'b1);

    // unmask after set
    pulse(7'h02);
    wr(8'h06, 8'hFC);
    @(negedge clk);
    chk_line("R7 late unmask", 1'b1);
    rd(8'h00, 8'h02, "R7 flag kept");

    // event colliding with read
    @(negedge clk);
    rd_en = 1'b1; addr = 8'h00; gl_pulse = 7'h40;
    exp_q.push_back(8'h00); tag_q.push_back("R4 pre-clear value");
    @(negedge clk);
    rd_en = 1'b0; gl_pulse = '0;
    rd(8'h00, 8'h40, "R4 flag survives");
    rd(8'h00, 8'h00, "R3 empty again");

    // charger field changes
    @(negedge clk); in_stat = 2'b11;
    @(negedge clk);
    chk_line("R9 input change unmasked", 1'b0);
    chg_state = 4'd9; loop_stat = 3'b010; cfg_forced = 1'b1;
    @(negedge clk); cfg_forced = 1'b0; chg_state = 4'd3;
    @(negedge clk);
    rd(8'h01, 8'h56, "R9 chg bits 1 2 4 6");
    chk_line("R9 release", 1'b1);
    @(negedge clk); loop_stat = 3'b011; therm_stat = 3'd0;
    @(negedge clk);
    rd(8'h01, 8'h09, "R9 loop bit3 therm bit0");

    // unmapped and flag writes
    wr(8'h00, 8'hFF);
    wr(8'h01, 8'hFF);
    rd(8'h00, 8'h00, "R12 glb flag write ignored");
    rd(8'h01, 8'h00, "R12 chg flag write ignored");
    rd(8'h03, 8'h00, "R12 unmapped read");
    chk_line("R12 line", 1'b1);

    // reset hides status changes
    @(negedge clk); rst = 1'b1;
    @(negedge clk); in_stat = 2'b01; chg_state = 4'd7; loop_stat = 3'b100;
    @(negedge clk); therm_stat = 3'd2;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    rd(8'h01, 8'h00, "R10 no flag after reset");
    rd(8'h06, 8'hFF, "R1 mask back to reset");
    chk_line("R10 line", 1'b1);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", 8'(exp_q.size()), 8'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule